// File: doc/BRIEF.md
# In-Band Packet Program Executor

This block runs a short program carried in a packet header at one switch hop. When `start` is accepted, it captures up to five 32-bit instruction words, the hop number, the per-hop slot size and the packet's scratch memory. It then executes the instructions one at a time, in order, against a local register file and a small statistics SRAM. When it finishes, it raises `done` for one cycle. The updated scratch memory is on `pkt_out`, and `halt` shows whether a failed condition stopped the program early.

Each instruction can copy a switch word into the packet, copy a packet word into the switch, perform an atomic compare-and-swap, or test a mask/value predicate that decides whether later instructions run. Packet operands can be absolute or hop-relative. Hop-relative operands let every hop write into its own slot of a preallocated region. The forwarding logic shares the switch storage through a single write port. Where both sides write the same word, the executor's write wins.

Top module: `pkt_prog_exec`

## Requirements
- R1: A high `start` while idle captures `prog`, `prog_len`, `hop`, `hop_size` and `pkt_in`. Instructions then run in order from word 0. A `prog_len` above 5 counts as 5. A `prog_len` of 0 ends with `pkt_out` equal to `pkt_in`.
- R2: Instruction word layout is opcode in [31:28], switch address in [27:12] and packet word offset in [11:0]. The opcodes are: 1 copies a switch word to an absolute packet word; 2 copies a switch word to a hop-relative packet word; 3 copies an absolute packet word to the switch; 4 copies a hop-relative packet word to the switch; 5 is compare-and-swap; 6 is conditional execute. Any other opcode does nothing.
- R3: A hop-relative packet index is hop × hop_size + offset, taken modulo the packet memory depth (16 words).
- R4: Compare-and-swap uses packet word p (hop-relative) as the expected value and word p+1 as the new value. On a match, word p+1 is written to the switch word. In every case, the switch word seen before the write is copied into packet word p.
- R5: A compare-and-swap mismatch skips every remaining instruction and ends with `halt` = 1.
- R6: Conditional execute reads the mask from hop-relative packet word p and the value from word p+1. It leaves packet memory unchanged. If (switch word AND mask) differs from value, every remaining instruction is skipped and `halt` = 1.
- R7: The register file occupies switch addresses 0x0000–0x0007 and the SRAM occupies 0x0100–0x010F. An instruction that names any other address changes nothing and does not halt the program.
- R8: While `wr_lock` is high, opcodes 3, 4 and 5 change neither switch nor packet state, and they never halt. Read-type opcodes still run.
- R9: If a forwarding write (`fwd_we`) and an executor write hit the same switch word on the same edge, the executor's value is kept.
- R10: `done` is high for exactly one cycle. Counting from the edge that accepts `start` as edge 1, `done` is seen after edge k+s+2. Here k is the number of instructions executed, including skipped ones, up to and including a halting one; s is how many of them address the SRAM. `halt` is valid with `done` and holds until the next `start`.
- R11: After reset, `busy`, `done` and `halt` are 0, `pkt_out` is all zero, and every register-file word reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a program (accepted while idle) |
| prog_len | input | 3 | Number of instructions |
| prog | input | 160 | Instruction words, word i at bits [32i+31:32i] |
| hop | input | 8 | Hop number from the header |
| hop_size | input | 8 | Words per hop slot |
| pkt_in | input | 512 | Packet scratch memory, word i at [32i+31:32i] |
| wr_lock | input | 1 | Administrator write lock |
| fwd_we | input | 1 | Forwarding-logic write enable |
| fwd_addr | input | 16 | Forwarding-logic switch address |
| fwd_wdata | input | 32 | Forwarding-logic write data |
| busy | output | 1 | Program in progress |
| done | output | 1 | One-cycle completion pulse |
| halt | output | 1 | Program was stopped by a failed condition |
| pkt_out | output | 512 | Updated packet scratch memory |

## Verification
The bench runs compare-and-swap through both outcomes. A design that skipped the write-back on a mismatch would leave the stale expected value in the packet. A design that failed to halt would let the trailing read overwrite an untouched word. Conditional execute is also driven both ways with a mask that hides differing bits, so a predicate that compares without masking would wrongly suppress the true case. Locked writes, unmapped addresses and undefined opcodes are each followed by reads that expose any stray change, including a locked compare-and-swap that must not halt. A forwarding write timed onto the exact edge of an executor store catches reversed write priority, and cycle counts from start to done expose a missing or extra SRAM read cycle.

// File: rtl/pkt_prog_exec.sv
module pkt_prog_exec #(
  parameter int N_INSTR    = 5,
  parameter int PKT_WORDS  = 16,
  parameter int REG_WORDS  = 8,
  parameter int SRAM_WORDS = 16,
  parameter logic [15:0] REG_BASE  = 16'h0000,
  parameter logic [15:0] SRAM_BASE = 16'h0100,
  localparam int PCW = $clog2(N_INSTR + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [PCW-1:0]            prog_len,
  input  logic [N_INSTR*32-1:0]     prog,
  input  logic [7:0]                hop,
  input  logic [7:0]                hop_size,
  input  logic [PKT_WORDS*32-1:0]   pkt_in,
  input  logic                      wr_lock,
  input  logic                      fwd_we,
  input  logic [15:0]               fwd_addr,
  input  logic [31:0]               fwd_wdata,
  output logic                      busy,
  output logic                      done,
  output logic                      halt,
  output logic [PKT_WORDS*32-1:0]   pkt_out
);
  localparam int PAW = $clog2(PKT_WORDS);
  localparam int RAW = $clog2(REG_WORDS);
  localparam int SAW = $clog2(SRAM_WORDS);
  localparam logic [3:0] OP_LD = 4'd1, OP_PUSH = 4'd2, OP_ST = 4'd3,
                         OP_POP = 4'd4, OP_CAS = 4'd5, OP_CEX = 4'd6;

  logic [N_INSTR-1:0][31:0]   prog_q;
  logic [PKT_WORDS-1:0][31:0] pkt;
  logic [REG_WORDS-1:0][31:0] regs;
  logic [31:0]                sram [SRAM_WORDS];
  logic [31:0]                sram_q;
  logic [PCW-1:0]             pc, len_q;
  logic [7:0]                 hop_q, hs_q;
  logic                       sram_rdy, stop_q;

  assign pkt_out = pkt;

  logic [31:0] cur;
  logic [3:0]  op;
  logic [15:0] sa, hidx, ra, sx, fra, fsx;
  logic [PAW-1:0] pa, pb;
  logic in_reg, in_sram, f_reg, f_sram, active, need_wait, go;
  logic cmp, pred, sw_we, pk_we, stop;
  logic [31:0] sw_val, sw_wd;

  assign cur    = (pc < PCW'(N_INSTR)) ? prog_q[pc] : '0;
  assign op     = cur[31:28];
  assign sa     = cur[27:12];
  assign hidx   = 16'(hop_q) * 16'(hs_q) + 16'(cur[11:0]);
  assign pa     = (op == OP_LD || op == OP_ST) ? cur[PAW-1:0] : hidx[PAW-1:0];
  assign pb     = pa + 1'b1;
  assign ra     = sa - REG_BASE;
  assign sx     = sa - SRAM_BASE;
  assign in_reg = ra < 16'(REG_WORDS);
  assign in_sram = sx < 16'(SRAM_WORDS);
  assign fra    = fwd_addr - REG_BASE;
  assign fsx    = fwd_addr - SRAM_BASE;
  assign f_reg  = fra < 16'(REG_WORDS);
  assign f_sram = fsx < 16'(SRAM_WORDS);
  assign sw_val = in_reg ? regs[ra[RAW-1:0]] : sram_q;

  assign active    = busy && (pc != len_q);
  assign need_wait = active && in_sram && !sram_rdy;
  assign go = active && !need_wait && (in_reg || in_sram) &&
              (op >= OP_LD && op <= OP_CEX) &&
              !(wr_lock && (op == OP_ST || op == OP_POP || op == OP_CAS));

  assign cmp   = sw_val == pkt[pa];
  assign pred  = (sw_val & pkt[pa]) == pkt[pb];
  assign sw_we = go && (op == OP_ST || op == OP_POP || (op == OP_CAS && cmp));
  assign sw_wd = (op == OP_CAS) ? pkt[pb] : pkt[pa];
  assign pk_we = go && (op == OP_LD || op == OP_PUSH || op == OP_CAS);
  assign stop  = go && ((op == OP_CAS && !cmp) || (op == OP_CEX && !pred));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; halt <= 1'b0; stop_q <= 1'b0;
      pc <= '0; len_q <= '0; sram_rdy <= 1'b0;
      prog_q <= '0; pkt <= '0; hop_q <= '0; hs_q <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy     <= 1'b1;
        pc       <= '0;
        len_q    <= (prog_len > PCW'(N_INSTR)) ? PCW'(N_INSTR) : prog_len;
        prog_q   <= prog;
        pkt      <= pkt_in;
        hop_q    <= hop;
        hs_q     <= hop_size;
        stop_q   <= 1'b0;
        halt     <= 1'b0;
        sram_rdy <= 1'b0;
      end else if (busy) begin
        if (pc == len_q) begin
          busy <= 1'b0;
          done <= 1'b1;
          halt <= stop_q;
        end else if (need_wait) begin
          sram_rdy <= 1'b1;
        end else begin
          sram_rdy <= 1'b0;
          if (pk_we) pkt[pa] <= sw_val;
          if (stop) begin
            stop_q <= 1'b1;
            pc     <= len_q;
          end else begin
            pc <= pc + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs <= '0;
    end else begin
      if (fwd_we && f_reg && !(sw_we && in_reg && ra == fra))
        regs[fra[RAW-1:0]] <= fwd_wdata;
      if (sw_we && in_reg)
        regs[ra[RAW-1:0]] <= sw_wd;
    end
  end

  always_ff @(posedge clk) begin
    if (fwd_we && f_sram && !(sw_we && in_sram && sx == fsx))
      sram[fsx[SAW-1:0]] <= fwd_wdata;
    if (sw_we && in_sram)
      sram[sx[SAW-1:0]] <= sw_wd;
    sram_q <= sram[sx[SAW-1:0]];
  end

  a_r1_pc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pc <= len_q && len_q <= PCW'(N_INSTR)));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_halt_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt) |-> done);

  a_r8_lock_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_lock && !fwd_we && !(start && !busy)) |=> $stable(regs));

  a_r5_mismatch_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !need_wait && op == OP_CAS && !cmp && !fwd_we) |=> $stable(regs));

  a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/pkt_prog_exec_tb.sv
module pkt_prog_exec_tb;
  localparam int N = 5;
  localparam int PW = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, wr_lock, fwd_we;
  logic [2:0] prog_len;
  logic [N*32-1:0] prog;
  logic [7:0] hop, hop_size;
  logic [PW*32-1:0] pkt_in;
  logic [15:0] fwd_addr;
  logic [31:0] fwd_wdata;
  logic busy, done, halt;
  logic [PW*32-1:0] pkt_out;

  pkt_prog_exec u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .prog_len(prog_len), .prog(prog),
    .hop(hop), .hop_size(hop_size), .pkt_in(pkt_in), .wr_lock(wr_lock),
    .fwd_we(fwd_we), .fwd_addr(fwd_addr), .fwd_wdata(fwd_wdata),
    .busy(busy), .done(done), .halt(halt), .pkt_out(pkt_out)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0] pin [PW];
  logic [31:0] ins [N];

  function automatic logic [31:0] mk(input logic [3:0] o, input logic [15:0] a,
                                     input logic [11:0] f);
    return {o, a, f};
  endfunction

  function automatic logic [31:0] pw(input int i);
    return pkt_out[i*32 +: 32];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic dflt_pkt();
    for (int i = 0; i < PW; i++) pin[i] = 32'h100 + i;
    for (int i = 0; i < N; i++) ins[i] = '0;
  endtask

  task automatic run(input logic [2:0] len, input logic [7:0] h, input logic [7:0] hs,
                     input logic lock, input logic fw);
    for (int i = 0; i < PW; i++) pkt_in[i*32 +: 32] = pin[i];
    for (int i = 0; i < N; i++) prog[i*32 +: 32] = ins[i];
    prog_len = len; hop = h; hop_size = hs; wr_lock = lock;
    @(negedge clk); start = 1'b1;
    @(posedge clk); cyc = 1;
    @(negedge clk); start = 1'b0; fwd_we = fw;
    @(posedge clk); cyc++;
    @(negedge clk); fwd_we = 1'b0;
    while (!done) begin
      @(posedge clk); cyc++;
      @(negedge clk);
    end
    wr_lock = 1'b0;
  endtask

  task automatic fwd_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); fwd_we = 1'b1; fwd_addr = a; fwd_wdata = d;
    @(negedge clk); fwd_we = 1'b0;
  endtask

  task automatic read_sw(input logic [15:0] a, output logic [31:0] v);
    dflt_pkt();
    ins[0] = mk(4'd1, a, 12'd15);
    run(3'd1, 8'd0, 8'd0, 1'b0, 1'b0);
    v = pw(15);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R11 busy", {31'b0, busy}, 32'd0);
    check("R11 done", {31'b0, done}, 32'd0);
    check("R11 halt", {31'b0, halt}, 32'd0);
    check("R11 pkt_out", {31'b0, |pkt_out}, 32'd0);
    read_sw(16'h0000, v);
    check("R11 reg0 zero", v, 32'd0);
  endtask

  task automatic t_push();
    fwd_write(16'h0002, 32'hAAAA0002);
    fwd_write(16'h0103, 32'h00005555);
    dflt_pkt();
    ins[0] = mk(4'd2, 16'h0002, 12'd0);
    ins[1] = mk(4'd2, 16'h0103, 12'd1);
    ins[2] = mk(4'd1, 16'h0002, 12'd15);
    run(3'd3, 8'd2, 8'd3, 1'b0, 1'b0);
    check("R3 push slot0", pw(6), 32'hAAAA0002);
    check("R3 push sram slot1", pw(7), 32'h00005555);
    check("R2 load absolute", pw(15), 32'hAAAA0002);
    check("R2 untouched", pw(8), 32'h108);
    check("R10 cycles sram", cyc, 6);
    check("R10 halt clear", {31'b0, halt}, 32'd0);
  endtask

  task automatic t_store();
    dflt_pkt();
    ins[0] = mk(4'd3, 16'h0004, 12'd1);
    ins[1] = mk(4'd4, 16'h0105, 12'd0);
    ins[2] = mk(4'd1, 16'h0004, 12'd10);
    ins[3] = mk(4'd1, 16'h0105, 12'd11);
    run(3'd4, 8'd1, 8'd4, 1'b0, 1'b0);
    check("R2 store abs", pw(10), 32'h101);
    check("R3 pop hop-rel", pw(11), 32'h104);
    check("R10 cycles two sram", cyc, 8);
  endtask

  task automatic t_cas_match();
    logic [31:0] v;
    fwd_write(16'h0001, 32'h77);
    dflt_pkt();
    pin[0] = 32'h77; pin[1] = 32'h99;
    ins[0] = mk(4'd5, 16'h0001, 12'd0);
    ins[1] = mk(4'd1, 16'h0001, 12'd8);
    run(3'd2, 8'd0, 8'd2, 1'b0, 1'b0);
    check("R4 match observed", pw(0), 32'h77);
    check("R4 match swapped", pw(8), 32'h99);
    check("R4 match no halt", {31'b0, halt}, 32'd0);
    dflt_pkt();
    fwd_write(16'h0107, 32'h33);
    pin[4] = 32'h33; pin[5] = 32'h44;
    ins[0] = mk(4'd5, 16'h0107, 12'd0);
    ins[1] = mk(4'd1, 16'h0107, 12'd12);
    run(3'd2, 8'd2, 8'd2, 1'b0, 1'b0);
    check("R4 sram cas", pw(12), 32'h44);
    check("R4 sram observed", pw(4), 32'h33);
    check("R10 sram cas cycles", cyc, 6);
    read_sw(16'h0107, v);
    check("R4 sram readback", v, 32'h44);
  endtask

  task automatic t_cas_miss();
    logic [31:0] v;
    dflt_pkt();
    pin[0] = 32'h50; pin[1] = 32'h60;
    ins[0] = mk(4'd5, 16'h0001, 12'd0);
    ins[1] = mk(4'd1, 16'h0001, 12'd8);
    run(3'd2, 8'd0, 8'd2, 1'b0, 1'b0);
    check("R4 miss writes observed", pw(0), 32'h99);
    check("R5 miss skips rest", pw(8), 32'h108);
    check("R5 miss halts", {31'b0, halt}, 32'd1);
    check("R10 halt cycles", cyc, 3);
    read_sw(16'h0001, v);
    check("R5 miss switch kept", v, 32'h99);
  endtask

  task automatic t_cexec();
    fwd_write(16'h0003, 32'h12345678);
    dflt_pkt();
    pin[2] = 32'h0000FF00; pin[3] = 32'h00005600;
    ins[0] = mk(4'd6, 16'h0003, 12'd0);
    ins[1] = mk(4'd1, 16'h0003, 12'd9);
    ins[2] = mk(4'd1, 16'h0003, 12'd10);
    run(3'd3, 8'd1, 8'd2, 1'b0, 1'b0);
    check("R6 true runs", pw(9), 32'h12345678);
    check("R6 true runs 2", pw(10), 32'h12345678);
    check("R6 mask kept", pw(2), 32'h0000FF00);
    check("R6 true no halt", {31'b0, halt}, 32'd0);
    pin[3] = 32'h00005700;
    run(3'd3, 8'd1, 8'd2, 1'b0, 1'b0);
    check("R6 false skips", pw(9), 32'h109);
    check("R6 false skips 2", pw(10), 32'h10A);
    check("R6 false halts", {31'b0, halt}, 32'd1);
  endtask

  task automatic t_unmapped();
    dflt_pkt();
    ins[0] = mk(4'd1, 16'h0800, 12'd5);
    ins[1] = mk(4'd5, 16'h0900, 12'd0);
    ins[2] = mk(4'd7, 16'h0003, 12'd6);
    ins[3] = mk(4'd1, 16'h0003, 12'd7);
    run(3'd4, 8'd0, 8'd2, 1'b0, 1'b0);
    check("R7 unmapped load", pw(5), 32'h105);
    check("R7 unmapped cas", pw(0), 32'h100);
    check("R2 bad opcode", pw(6), 32'h106);
    check("R7 continues", pw(7), 32'h12345678);
    check("R7 no halt", {31'b0, halt}, 32'd0);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    dflt_pkt();
    pin[0] = 32'h98; pin[1] = 32'hDEAD;
    ins[0] = mk(4'd3, 16'h0004, 12'd2);
    ins[1] = mk(4'd4, 16'h0105, 12'd4);
    ins[2] = mk(4'd5, 16'h0001, 12'd0);
    ins[3] = mk(4'd1, 16'h0004, 12'd13);
    run(3'd4, 8'd0, 8'd2, 1'b1, 1'b0);
    check("R8 read allowed", pw(13), 32'h101);
    check("R8 cas skipped", pw(0), 32'h98);
    check("R8 no halt", {31'b0, halt}, 32'd0);
    read_sw(16'h0001, v);
    check("R8 reg1 kept", v, 32'h99);
    read_sw(16'h0105, v);
    check("R8 sram kept", v, 32'h104);
  endtask

  task automatic t_prio();
    logic [31:0] v;
    fwd_addr = 16'h0006; fwd_wdata = 32'hBAD;
    dflt_pkt();
    ins[0] = mk(4'd3, 16'h0006, 12'd3);
    run(3'd1, 8'd0, 8'd0, 1'b0, 1'b1);
    read_sw(16'h0006, v);
    check("R9 executor wins", v, 32'h103);
  endtask

  task automatic t_len();
    dflt_pkt();
    for (int i = 0; i < N; i++) ins[i] = mk(4'd1, 16'h0003, 12'(i));
    ins[4] = mk(4'd2, 16'h0001, 12'd2);
    run(3'd5, 8'd5, 8'd3, 1'b0, 1'b0);
    check("R1 five in order", pw(3), 32'h12345678);
    check("R3 wraps mod depth", pw(1), 32'h99);
    check("R10 five cycles", cyc, 7);
    dflt_pkt();
    for (int i = 0; i < N; i++) ins[i] = mk(4'd1, 16'h0003, 12'(i + 8));
    run(3'd7, 8'd0, 8'd0, 1'b0, 1'b0);
    check("R1 clamp cycles", cyc, 7);
    check("R1 clamp last", pw(12), 32'h12345678);
    run(3'd0, 8'd0, 8'd0, 1'b0, 1'b0);
    check("R1 empty cycles", cyc, 2);
    check("R1 empty unchanged", pw(8), 32'h108);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual hung expected done");
    summary();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; wr_lock = 1'b0; fwd_we = 1'b0;
    fwd_addr = '0; fwd_wdata = '0; prog_len = '0; prog = '0;
    hop = '0; hop_size = '0; pkt_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_push();
    t_store();
    t_cas_match();
    t_cas_miss();
    t_cexec();
    t_unmapped();
    t_lock();
    t_prio();
    t_len();
    summary();
  end
endmodule